// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the horizontal and vertical raster timing for a TFT panel from three configuration inputs: a horizontal timing word, a vertical timing word and a small polarity vector. It runs on the pixel clock. It drives sync, data-enable and a pixel-clock-edge select, together with the current pixel and line position and a one-cycle frame-start strobe. A line is built from sync, back porch, active pixels and front porch, in that order. A frame is built from the same four phases, counted in lines.

The block also keeps a frame-buffer base address in two stages. Software writes a pending base at any time. The block copies the pending value into the live base when the raster returns to the top of vertical sync, and in that same cycle it sets a raw "new base taken" status bit. That bit reaches the interrupt output only while the mask input is high, and a clear pulse removes it.

Top module: `lcd_raster_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is zero: sync, data-enable, edge select, frame strobe, both counters, live base, raw status and interrupt.
- R2: The raster runs only while ctrlEnable, ctrlTft and ctrlPower are all high. If any of the three is low, the next clock forces every timing output and both counters to zero. On the first clock with all three high, the position becomes pixel 0 of line 0.
- R3: The horizontal word is decoded as follows. Bits 7:2 hold active width/16 minus one. Bits 15:8 hold sync width minus one. Bits 23:16 hold front porch minus one. Bits 31:24 hold back porch minus one. Bits 1:0 are ignored. The raw hsync level is high for pixel positions below the sync width.
- R4: The vertical word is decoded as follows. Bits 9:0 hold active lines minus one. Bits 15:10 hold sync width minus one. Bits 23:16 hold the front porch and bits 31:24 hold the back porch, both as raw line counts that may be zero. The raw vsync level is high for line positions below the sync width.
- R5: The raw data-enable is high only when the pixel position lies in [sync+back porch, sync+back porch+width) and the line position lies in [vsync+vback porch, vsync+vback porch+lines).
- R6: polCfg bit 0 inverts hsync, bit 1 inverts vsync, bit 2 inverts data-enable and bit 3 drives the pixel-clock-edge select. Inversion applies only while the raster runs; while it is stopped, all these outputs stay low.
- R7: pixelCount steps by one per clock from 0 to line total minus one, then wraps to 0. lineCount advances on that wrap and returns to 0 after frame total minus one lines. sync, data-enable and the frame strobe are valid in the same cycle as the counters they belong to.
- R8: frameStart is high for exactly the cycles in which the position is pixel 0 of line 0 while running.
- R9: A base write stores the data with its two low bits cleared as the pending base. The live base takes the pending value only in a cycle with frameStart high. A write in that same edge does not reach the live base until the next frame.
- R10: rawStatus is set in every frameStart cycle. An irqClear pulse clears it on the next edge, but a set in the same edge takes priority. irqOut equals rawStatus AND irqMask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlEnable | input | 1 | Raster enable bit |
| ctrlTft | input | 1 | TFT mode bit, required to run |
| ctrlPower | input | 1 | Panel power bit, required to run |
| horizWord | input | 32 | Horizontal timing fields |
| vertWord | input | 32 | Vertical timing fields |
| polCfg | input | 4 | Polarity and pixel-clock-edge controls |
| baseWrEn | input | 1 | Write strobe for the pending base |
| baseWrData | input | ADDR_W | Pending base address data |
| irqMask | input | 1 | Interrupt enable for the base-taken status |
| irqClear | input | 1 | Write-one-to-clear pulse for the status |
| hsyncOut | output | 1 | Horizontal sync after polarity |
| vsyncOut | output | 1 | Vertical sync after polarity |
| deOut | output | 1 | Data-enable after polarity |
| pclkInvOut | output | 1 | Pixel clock edge select |
| frameStart | output | 1 | One-cycle strobe at top of frame |
| pixelCount | output | HCNT_W | Pixel position within the line |
| lineCount | output | VCNT_W | Line position within the frame |
| liveBase | output | ADDR_W | Base address in use |
| rawStatus | output | 1 | Unmasked base-taken status |
| irqOut | output | 1 | Masked interrupt |

## Verification
The raster is tried under a series of seeded random timing words with small fields, so that each run covers several full frames. These words include zero vertical porches and single-line sync, which separate the biased and unbiased field decodes and show that empty phases are skipped. A per-cycle reference model, built from the field definitions, checks every output. Random polarity, random base writes, clear pulses, mask toggles and short enable drops show that inversion, the two-stage base, the set-over-clear rule and the restart from position zero behave as required. Directed cases cover reset, running with one control bit missing, and a clear held through a frame top.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;
  // Strobes the control half hands to the datapath each cycle,
  // all describing the position the counters move to at the next edge.
  typedef struct packed {
    logic run;       // raster runs after this edge
    logic hSync;     // in horizontal sync phase
    logic vSync;     // in vertical sync phase
    logic hAct;      // in horizontal active window
    logic vAct;      // in vertical active window
    logic frameTop;  // pixel 0 of line 0
  } strobes_t;
endpackage

// File: rtl/lcd_timing_ctrl.sv
module lcd_timing_ctrl
  import lcd_timing_pkg::*;
#(
  parameter int HCNT_W = 12,
  parameter int VCNT_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enAll,
  input  logic [31:0]       horizWord,
  input  logic [31:0]       vertWord,
  output logic [HCNT_W-1:0] pixelCount,
  output logic [VCNT_W-1:0] lineCount,
  output strobes_t          strobes
);
  localparam logic [HCNT_W-1:0] H_ONE = HCNT_W'(1);
  localparam logic [VCNT_W-1:0] V_ONE = VCNT_W'(1);

  logic running;
  logic [HCNT_W-1:0] hSyncLen, hBackLen, hActLen, hFrontLen;
  logic [HCNT_W-1:0] hActStart, hActEnd, hTotal, hNext;
  logic [VCNT_W-1:0] vSyncLen, vBackLen, vActLen, vFrontLen;
  logic [VCNT_W-1:0] vActStart, vActEnd, vTotal, vNext;
  logic lineWrap;
  logic unusedBits;

  assign unusedBits = ^horizWord[1:0];

  // Field decode: horizontal fields all carry a minus-one bias,
  // vertical porches are raw counts.
  always_comb begin
    hSyncLen  = HCNT_W'(horizWord[15:8]) + H_ONE;
    hFrontLen = HCNT_W'(horizWord[23:16]) + H_ONE;
    hBackLen  = HCNT_W'(horizWord[31:24]) + H_ONE;
    hActLen   = (HCNT_W'(horizWord[7:2]) + H_ONE) << 4;
    hActStart = hSyncLen + hBackLen;
    hActEnd   = hActStart + hActLen;
    hTotal    = hActEnd + hFrontLen;

    vActLen   = VCNT_W'(vertWord[9:0]) + V_ONE;
    vSyncLen  = VCNT_W'(vertWord[15:10]) + V_ONE;
    vFrontLen = VCNT_W'(vertWord[23:16]);
    vBackLen  = VCNT_W'(vertWord[31:24]);
    vActStart = vSyncLen + vBackLen;
    vActEnd   = vActStart + vActLen;
    vTotal    = vActEnd + vFrontLen;
  end

  always_comb begin
    lineWrap = running && (pixelCount >= hTotal - H_ONE);
    if (!running || lineWrap) hNext = '0;
    else                      hNext = pixelCount + H_ONE;
    if (!running)                          vNext = '0;
    else if (!lineWrap)                    vNext = lineCount;
    else if (lineCount >= vTotal - V_ONE)  vNext = '0;
    else                                   vNext = lineCount + V_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running    <= 1'b0;
      pixelCount <= '0;
      lineCount  <= '0;
    end else begin
      running    <= enAll;
      pixelCount <= enAll ? hNext : '0;
      lineCount  <= enAll ? vNext : '0;
    end
  end

  always_comb begin
    strobes.run      = enAll;
    strobes.hSync    = hNext < hSyncLen;
    strobes.vSync    = vNext < vSyncLen;
    strobes.hAct     = (hNext >= hActStart) && (hNext < hActEnd);
    strobes.vAct     = (vNext >= vActStart) && (vNext < vActEnd);
    strobes.frameTop = (hNext == '0) && (vNext == '0);
  end

  // R7
  line_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running) && pixelCount != '0) |-> (pixelCount == $past(pixelCount) + H_ONE));
endmodule

// File: rtl/lcd_timing_dp.sv
module lcd_timing_dp
  import lcd_timing_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [3:0]        polCfg,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic              irqMask,
  input  logic              irqClear,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              deOut,
  output logic              pclkInvOut,
  output logic              frameStart,
  output logic [ADDR_W-1:0] liveBase,
  output logic              rawStatus,
  output logic              irqOut
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

  logic [ADDR_W-1:0] pendBase;
  logic commit;

  assign commit = strobes.run && strobes.frameTop;

  // Output register stage with polarity applied only while running.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsyncOut   <= 1'b0;
      vsyncOut   <= 1'b0;
      deOut      <= 1'b0;
      pclkInvOut <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      hsyncOut   <= strobes.run & (strobes.hSync ^ polCfg[0]);
      vsyncOut   <= strobes.run & (strobes.vSync ^ polCfg[1]);
      deOut      <= strobes.run & ((strobes.hAct & strobes.vAct) ^ polCfg[2]);
      pclkInvOut <= strobes.run & polCfg[3];
      frameStart <= commit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendBase  <= '0;
      liveBase  <= '0;
      rawStatus <= 1'b0;
    end else begin
      if (baseWrEn) pendBase <= baseWrData & ALIGN_MASK;
      if (commit)   liveBase <= pendBase;
      if (commit)        rawStatus <= 1'b1;
      else if (irqClear) rawStatus <= 1'b0;
    end
  end

  assign irqOut = rawStatus & irqMask;

  // R9
  base_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (liveBase != $past(liveBase)) |-> frameStart);
  // R10
  status_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawStatus) |-> frameStart);
  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irqClear) && !frameStart) |-> !rawStatus);
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcd_timing_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HCNT_W = 12,
  parameter int VCNT_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlEnable,
  input  logic              ctrlTft,
  input  logic              ctrlPower,
  input  logic [31:0]       horizWord,
  input  logic [31:0]       vertWord,
  input  logic [3:0]        polCfg,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic              irqMask,
  input  logic              irqClear,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              deOut,
  output logic              pclkInvOut,
  output logic              frameStart,
  output logic [HCNT_W-1:0] pixelCount,
  output logic [VCNT_W-1:0] lineCount,
  output logic [ADDR_W-1:0] liveBase,
  output logic              rawStatus,
  output logic              irqOut
);
  logic     enAll;
  strobes_t strobes;

  assign enAll = ctrlEnable & ctrlTft & ctrlPower;

  lcd_timing_ctrl #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enAll(enAll),
    .horizWord(horizWord), .vertWord(vertWord),
    .pixelCount(pixelCount), .lineCount(lineCount), .strobes(strobes)
  );

  lcd_timing_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .polCfg(polCfg),
    .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .irqMask(irqMask), .irqClear(irqClear),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
    .pclkInvOut(pclkInvOut), .frameStart(frameStart),
    .liveBase(liveBase), .rawStatus(rawStatus), .irqOut(irqOut)
  );

  // R8
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (pixelCount == '0 && lineCount == '0));
  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enAll) |-> (!hsyncOut && !vsyncOut && !deOut && !frameStart && !pclkInvOut));
endmodule

// File: tb/lcd_raster_timer_bench.sv
module lcd_raster_timer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlEnable = 0, ctrlTft = 0, ctrlPower = 0;
  logic [31:0] horizWord = 0, vertWord = 0;
  logic [3:0]  polCfg = 0;
  logic baseWrEn = 0;
  logic [31:0] baseWrData = 0;
  logic irqMask = 0, irqClear = 0;
  logic hsyncOut, vsyncOut, deOut, pclkInvOut, frameStart, rawStatus, irqOut;
  logic [11:0] pixelCount;
  logic [10:0] lineCount;
  logic [31:0] liveBase;

  int nChecks = 0, nFail = 0;
  int cAw, cHsw, cHbp, cHfp, cLines, cVsw, cVbp, cVfp;
  int ep = 0, el = 0;
  bit erun = 0, eEn = 0, eStat = 0;
  logic [31:0] eShadow = 0, eLive = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lcd_raster_timer u_lcd_raster_timer (
    .clk(clk), .rstN(rstN), .ctrlEnable(ctrlEnable), .ctrlTft(ctrlTft),
    .ctrlPower(ctrlPower), .horizWord(horizWord), .vertWord(vertWord),
    .polCfg(polCfg), .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .irqMask(irqMask), .irqClear(irqClear), .hsyncOut(hsyncOut),
    .vsyncOut(vsyncOut), .deOut(deOut), .pclkInvOut(pclkInvOut),
    .frameStart(frameStart), .pixelCount(pixelCount), .lineCount(lineCount),
    .liveBase(liveBase), .rawStatus(rawStatus), .irqOut(irqOut)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Build timing words from field values (R3, R4 encodings).
  task automatic setCfg(input int awF, hswF, hbpF, hfpF, lnF, vswF, vbpF, vfpF);
    horizWord = {8'(hbpF), 8'(hfpF), 8'(hswF), 6'(awF), 2'($urandom % 4)};
    vertWord  = {8'(vbpF), 8'(vfpF), 6'(vswF), 10'(lnF)};
    cAw = (awF + 1) * 16; cHsw = hswF + 1; cHbp = hbpF + 1; cHfp = hfpF + 1;
    cLines = lnF + 1; cVsw = vswF + 1; cVbp = vbpF; cVfp = vfpF;
  endtask

  function automatic bit expH(); return ep < cHsw; endfunction
  function automatic bit expV(); return el < cVsw; endfunction
  function automatic bit expDe();
    return (ep >= cHsw + cHbp) && (ep < cHsw + cHbp + cAw) &&
           (el >= cVsw + cVbp) && (el < cVsw + cVbp + cLines);
  endfunction

  // One clock: update model at the edge, compare at the falling edge.
  task automatic cycle();
    bit en, top;
    int tot, vtot;
    @(posedge clk);
    en = ctrlEnable && ctrlTft && ctrlPower;
    tot = cHsw + cHbp + cAw + cHfp;
    vtot = cVsw + cVbp + cLines + cVfp;
    if (en && erun) begin
      if (ep >= tot - 1) begin
        ep = 0;
        if (el >= vtot - 1) el = 0; else el++;
      end else ep++;
    end else begin
      ep = 0; el = 0;
    end
    top = en && ep == 0 && el == 0;
    if (top) begin eLive = eShadow; eStat = 1; end
    else if (irqClear) eStat = 0;
    if (baseWrEn) eShadow = baseWrData & ~32'd3;
    erun = en; eEn = en;
    @(negedge clk);
    chk(pixelCount == 12'(ep), "R7 pixelCount", pixelCount, ep);
    chk(lineCount == 11'(el), "R7 lineCount", lineCount, el);
    chk(hsyncOut == (eEn & (expH() ^ polCfg[0])), "R3 hsync", hsyncOut, eEn & (expH() ^ polCfg[0]));
    chk(vsyncOut == (eEn & (expV() ^ polCfg[1])), "R4 vsync", vsyncOut, eEn & (expV() ^ polCfg[1]));
    chk(deOut == (eEn & (expDe() ^ polCfg[2])), "R5 de", deOut, eEn & (expDe() ^ polCfg[2]));
    chk(pclkInvOut == (eEn & polCfg[3]), "R6 pclk edge", pclkInvOut, eEn & polCfg[3]);
    chk(frameStart == top, "R8 frameStart", frameStart, top);
    chk(liveBase == eLive, "R9 liveBase", liveBase, eLive);
    chk(rawStatus == eStat, "R10 rawStatus", rawStatus, eStat);
    chk(irqOut == (eStat & irqMask), "R10 irqOut", irqOut, eStat & irqMask);
  endtask

  task automatic randomInputs();
    baseWrEn   = ($urandom % 16) == 0;
    baseWrData = $urandom;
    irqClear   = ($urandom % 8) == 0;
    if (($urandom % 32) == 0) irqMask = ~irqMask;
  endtask

  initial begin
    int seedVal;
    seedVal = $urandom(32'h1cd5);
    setCfg(0, 1, 2, 1, 2, 0, 1, 0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!hsyncOut && !vsyncOut && !deOut && !pclkInvOut && !frameStart, "R1 timing outs", 1, 0);
    chk(pixelCount == 0 && lineCount == 0, "R1 counters", pixelCount, 0);
    chk(liveBase == 0 && !rawStatus && !irqOut, "R1 base/status", liveBase, 0);
    rstN = 1'b1;
    cycle();
    chk(!hsyncOut && !deOut && liveBase == 0 && !rawStatus, "R1 after release", hsyncOut, 0);

    // R2: two of three control bits, inverted polarity must not show
    ctrlEnable = 1; ctrlTft = 1; ctrlPower = 0; polCfg = 4'hF;
    baseWrEn = 1; baseWrData = 32'h1234_5677;
    cycle();
    baseWrEn = 0;
    repeat (40) cycle();
    chk(liveBase == 0, "R2 no commit while stopped", liveBase, 0);
    ctrlPower = 1; ctrlTft = 0;
    repeat (10) cycle();
    ctrlTft = 1; polCfg = 0; irqMask = 1;
    repeat (300) cycle();
    chk(liveBase == 32'h1234_5674, "R9 aligned base", liveBase, 32'h1234_5674);

    // R10: clear held through frame tops, set must win at each top
    irqClear = 1;
    repeat (250) cycle();
    irqClear = 0;

    // Random configurations
    for (int k = 0; k < 24; k++) begin
      int frameLen;
      ctrlEnable = 0;
      repeat (3) cycle();
      setCfg($urandom % 2, $urandom % 4, $urandom % 4, $urandom % 4,
             $urandom % 4, $urandom % 2, $urandom % 3, $urandom % 3);
      polCfg = 4'($urandom);
      ctrlEnable = 1;
      frameLen = (cHsw + cHbp + cAw + cHfp) * (cVsw + cVbp + cLines + cVfp);
      for (int c = 0; c < 2 * frameLen + 7; c++) begin
        randomInputs();
        if (k % 5 == 4 && c == frameLen / 2) ctrlPower = 0;
        else ctrlPower = 1;
        cycle();
      end
      baseWrEn = 0; irqClear = 0;
    end
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule